// File: doc/BRIEF.md
# Fractional-Increment Constant-Rate Timekeeping Counter

This block keeps a 64-bit free-running time count that advances at a fixed nominal rate, 6.144 MHz, whatever reference clock drives it. It does this with a rational increment. On every reference clock, a remainder accumulator adds a programmed numerator. When the sum reaches a programmed denominator, the denominator is subtracted and the count steps by one. The count therefore advances by num/den per clock on average. For a 38.4 MHz reference the ratio is 4/25. For 19.2 MHz it is 8/25, for 12 MHz 64/125, for 13 MHz 768/1625, for 26 MHz 384/1625 and for 27 MHz 256/1125.

When the reference clock changes, software writes a new numerator and denominator. The pair takes effect as one unit, and the remainder carries over, so the count never jumps. A small register port gives access to the ratio registers and to the count. The count is read as two 32-bit words, and a shadow keeps that two-word read coherent.

Top module: `frc_master_counter`

## Requirements
- R1: After reset the count equals the parameter CNT_RST, the remainder is zero, the active ratio is 4/25, and the numerator and denominator registers read 4 and 25.
- R2: On each clock the remainder adds the active numerator. When the sum is at least the active denominator, the denominator is subtracted and the count steps by exactly one. The count never steps by more than one per clock, so over den clocks it advances by exactly num.
- R3: The remainder always stays below the active denominator. When a new ratio is applied, the remainder is kept, limited to at most the new denominator minus one.
- R4: The numerator register is at byte offset 0x10 and the denominator register at 0x14. The ratio is bits [11:0]. Bits [31:12] are stored and read back as written, and they have no effect on counting.
- R5: A write to one ratio register marks it pending. The clock edge after the one where both are pending, written in either order, loads the pair into the active ratio; that edge still counts with the old ratio. A write to only one of the two changes nothing.
- R6: A pending pair with den = 0 or num >= den is discarded. The active ratio is unchanged and both pending marks clear.
- R7: A read of offset 0x00 returns count bits [31:0] in the same cycle and captures count bits [63:32] into a shadow. A read of offset 0x04 returns the shadow. The shadow changes only on a read of 0x00.
- R8: Writes to 0x00, 0x04 or any unmapped offset have no effect. Reads of unmapped offsets return zero.
- R9: The count carries across the 32-bit word boundary, and it continues without a jump when the ratio changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (used for shadow capture) |
| reg_addr_i | input | 5 | Byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from address |
| count_o | output | 64 | Time count |

## Verification
The bench uses the default 12-bit ratio field and sets CNT_RST just below a 32-bit carry. Word reads therefore cross the low-word wrap within a few hundred clocks, and the shadow coherence can be checked there. Every pair with a denominator up to 12 is swept, together with the six ratios for the listed reference clocks. Moving from large to small denominators exercises the remainder limit. The count is compared every cycle against an arithmetic model, and each newly applied ratio must advance the count by exactly num over den clocks.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam int unsigned OFF_CNT_LO = 32'h00;
  localparam int unsigned OFF_CNT_HI = 32'h04;
  localparam int unsigned OFF_NUM    = 32'h10;
  localparam int unsigned OFF_DEN    = 32'h14;
endpackage

// File: rtl/frc_regs.sv
module frc_regs #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned RATIO_W = 12,
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned DEF_NUM = 4,
  parameter int unsigned DEF_DEN = 25
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic               re_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]   cnt_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [RATIO_W-1:0] stg_num_o,
  output logic [RATIO_W-1:0] stg_den_o,
  output logic               apply_o
);
  import frc_pkg::*;
  localparam int unsigned HI_W = CNT_W - DATA_W;

  logic [DATA_W-1:0] num_q, den_q;
  logic [HI_W-1:0]   shadow_q;
  logic              num_pend_q, den_pend_q;
  logic              sel_lo, sel_hi, sel_num, sel_den;

  assign sel_lo  = addr_i == ADDR_W'(OFF_CNT_LO);
  assign sel_hi  = addr_i == ADDR_W'(OFF_CNT_HI);
  assign sel_num = addr_i == ADDR_W'(OFF_NUM);
  assign sel_den = addr_i == ADDR_W'(OFF_DEN);
  assign apply_o = num_pend_q && den_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_q      <= DATA_W'(DEF_NUM);
      den_q      <= DATA_W'(DEF_DEN);
      num_pend_q <= 1'b0;
      den_pend_q <= 1'b0;
      shadow_q   <= '0;
    end else begin
      if (we_i && sel_num) begin
        num_q      <= wdata_i;
        num_pend_q <= 1'b1;
      end else if (apply_o) begin
        num_pend_q <= 1'b0;
      end
      if (we_i && sel_den) begin
        den_q      <= wdata_i;
        den_pend_q <= 1'b1;
      end else if (apply_o) begin
        den_pend_q <= 1'b0;
      end
      if (re_i && sel_lo) shadow_q <= cnt_i[CNT_W-1:DATA_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_lo)       rdata_o = cnt_i[DATA_W-1:0];
    else if (sel_hi)  rdata_o = DATA_W'(shadow_q);
    else if (sel_num) rdata_o = num_q;
    else if (sel_den) rdata_o = den_q;
  end

  assign stg_num_o = num_q[RATIO_W-1:0];
  assign stg_den_o = den_q[RATIO_W-1:0];

  // R7: shadow moves only on a low-word read
  a_r7_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(re_i && sel_lo) |=> $stable(shadow_q));
endmodule

// File: rtl/frc_accum.sv
module frc_accum #(
  parameter int unsigned RATIO_W = 12,
  parameter int unsigned DEF_NUM = 4,
  parameter int unsigned DEF_DEN = 25
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               apply_i,
  input  logic [RATIO_W-1:0] stg_num_i,
  input  logic [RATIO_W-1:0] stg_den_i,
  output logic               inc_o
);
  localparam int unsigned SUM_W = RATIO_W + 1;

  logic [RATIO_W-1:0] act_num_q, act_den_q, acc_q;
  logic [SUM_W-1:0]   sum;
  logic [RATIO_W-1:0] acc_step, acc_next;
  logic               stg_ok;

  assign sum      = {1'b0, acc_q} + {1'b0, act_num_q};
  assign inc_o    = sum >= {1'b0, act_den_q};
  assign acc_step = inc_o ? RATIO_W'(sum - {1'b0, act_den_q}) : RATIO_W'(sum);
  assign stg_ok   = (stg_den_i != '0) && (stg_num_i < stg_den_i);

  always_comb begin
    acc_next = acc_step;
    if (apply_i && stg_ok && acc_step >= stg_den_i) acc_next = stg_den_i - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_num_q <= RATIO_W'(DEF_NUM);
      act_den_q <= RATIO_W'(DEF_DEN);
      acc_q     <= '0;
    end else begin
      acc_q <= acc_next;
      if (apply_i && stg_ok) begin
        act_num_q <= stg_num_i;
        act_den_q <= stg_den_i;
      end
    end
  end

  a_r3_acc_below_den: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q < act_den_q);
  a_r6_ratio_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_num_q < act_den_q);
  a_r5_ratio_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply_i |=> $stable(act_num_q) && $stable(act_den_q));
endmodule

// File: rtl/frc_count.sv
module frc_count #(
  parameter int unsigned     CNT_W   = 64,
  parameter logic [CNT_W-1:0] CNT_RST = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= CNT_RST;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end

  a_r2_step_le_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_o - $past(cnt_o)) <= CNT_W'(1));
endmodule

// File: rtl/frc_master_counter.sv
module frc_master_counter #(
  parameter int unsigned      CNT_W   = 64,
  parameter int unsigned      DATA_W  = 32,
  parameter int unsigned      ADDR_W  = 5,
  parameter int unsigned      RATIO_W = 12,
  parameter int unsigned      DEF_NUM = 4,
  parameter int unsigned      DEF_DEN = 25,
  parameter logic [CNT_W-1:0] CNT_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [RATIO_W-1:0] stg_num, stg_den;
  logic               apply, inc;

  frc_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RATIO_W(RATIO_W), .CNT_W(CNT_W),
    .DEF_NUM(DEF_NUM), .DEF_DEN(DEF_DEN)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .re_i(reg_re_i),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .cnt_i(count_o),
    .rdata_o(reg_rdata_o), .stg_num_o(stg_num), .stg_den_o(stg_den),
    .apply_o(apply)
  );

  frc_accum #(
    .RATIO_W(RATIO_W), .DEF_NUM(DEF_NUM), .DEF_DEN(DEF_DEN)
  ) u_accum (
    .clk_i(clk_i), .rst_ni(rst_ni), .apply_i(apply),
    .stg_num_i(stg_num), .stg_den_i(stg_den), .inc_o(inc)
  );

  frc_count #(.CNT_W(CNT_W), .CNT_RST(CNT_RST)) u_count (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(inc), .cnt_o(count_o)
  );
endmodule

// File: tb/tb_frc_master_counter.sv
module tb_frc_master_counter;
  localparam logic [63:0] RST_VAL = 64'h0000_0002_FFFF_FF80;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [4:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [63:0] count_o;

  frc_master_counter #(.CNT_RST(RST_VAL)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_re_i(reg_re_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .count_o(count_o)
  );

  always #5 clk_i = ~clk_i;

  int checks = 0, fails = 0;
  bit done = 0;

  // arithmetic model
  logic [63:0] m_cnt = RST_VAL;
  logic [31:0] m_shadow = '0, m_numr = 32'd4, m_denr = 32'd25;
  int m_acc = 0, m_num = 4, m_den = 25;
  bit pn = 0, pd = 0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    int sum, acc_s, sn, sd;
    bit inc;
    sum = m_acc + m_num;
    inc = sum >= m_den;
    acc_s = inc ? sum - m_den : sum;
    if (reg_re_i && reg_addr_i == 5'h00) m_shadow = m_cnt[63:32];
    if (inc) m_cnt = m_cnt + 1;
    if (pn && pd) begin
      sn = int'(m_numr[11:0]);
      sd = int'(m_denr[11:0]);
      if (sd != 0 && sn < sd) begin  // R6 rejection otherwise
        m_num = sn; m_den = sd;
        if (acc_s >= sd) acc_s = sd - 1;  // R3 clamp
      end
      pn = 0; pd = 0;
    end
    if (reg_we_i && reg_addr_i == 5'h10) begin m_numr = reg_wdata_i; pn = 1; end
    if (reg_we_i && reg_addr_i == 5'h14) begin m_denr = reg_wdata_i; pd = 1; end
    m_acc = acc_s;
  endtask

  task automatic step();
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    check("R2/R9 count", count_o, m_cnt);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    step();
    reg_we_i = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    reg_re_i = 1; reg_addr_i = a;
    #1 d = reg_rdata_o;
    step();
    reg_re_i = 0;
  endtask

  task automatic set_ratio(int n, int d, bit den_first);
    if (den_first) begin wr(5'h14, 32'(d)); wr(5'h10, 32'(n)); end
    else begin wr(5'h10, 32'(n)); wr(5'h14, 32'(d)); end
  endtask

  // R2: once a ratio is active, den clocks advance count by exactly num
  task automatic rate_check(int n, int d);
    logic [63:0] c0;
    step();  // apply edge
    c0 = count_o;
    repeat (d) step();
    check("R2 rate over den clocks", count_o - c0, 64'(n));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, lo;
    logic [63:0] c0;
    int pairs [6][2] = '{'{4,25}, '{8,25}, '{64,125}, '{768,1625}, '{384,1625}, '{256,1125}};
    repeat (3) @(negedge clk_i);
    check("R1 reset count", count_o, RST_VAL);
    rst_ni = 1;
    rd(5'h10, d); check("R1 num reset", 64'(d), 64'd4);
    rd(5'h14, d); check("R1 den reset", 64'(d), 64'd25);
    c0 = count_o;
    repeat (25) step();
    check("R1 default 4/25 rate", count_o - c0, 64'd4);

    // R5: only numerator written, nothing changes
    wr(5'h10, 32'd11);
    repeat (40) step();
    wr(5'h14, 32'd12);
    rate_check(11, 12);

    // R7/R9: coherent word reads across the low-word carry
    for (int i = 0; i < 200; i++) begin
      c0 = m_cnt;
      rd(5'h00, lo);
      check("R7 low word", 64'(lo), 64'(c0[31:0]));
      rd(5'h04, d);
      check("R7 shadow high", 64'(d), 64'(c0[63:32]));
    end
    check("R9 carry reached", 64'(m_cnt[63:32]), 64'd3);

    // R2/R3/R5: exhaustive small pairs, both write orders
    for (int dd = 12; dd >= 1; dd--)
      for (int nn = 0; nn < dd; nn++) begin
        set_ratio(nn, dd, nn[0]);
        rate_check(nn, dd);
        repeat (dd) step();
      end
    for (int dd = 1; dd <= 12; dd++) begin
      set_ratio(dd - 1, dd, 1'b0);
      rate_check(dd - 1, dd);
    end

    // listed reference-clock ratios
    foreach (pairs[k]) begin
      set_ratio(pairs[k][0], pairs[k][1], 1'b0);
      rate_check(pairs[k][0], pairs[k][1]);
    end

    // R6: invalid pairs rejected, old ratio 256/1125 stays
    set_ratio(9, 9, 1'b0);
    step();
    set_ratio(3, 0, 1'b1);
    rd(5'h14, d); check("R6 staged den readback", 64'(d), 64'd0);
    c0 = count_o;
    repeat (1125) step();
    check("R6 rate unchanged", count_o - c0, 64'd256);

    // R4: upper field bits stored, ignored for counting
    set_ratio(32'hFFFF_F003, 32'h1234_500A, 1'b0);
    rate_check(3, 10);
    rd(5'h10, d); check("R4 num upper kept", 64'(d), 64'hFFFF_F003);
    rd(5'h14, d); check("R4 den upper kept", 64'(d), 64'h1234_500A);

    // R8: writes to count/unmapped ignored, unmapped reads zero
    wr(5'h00, 32'h0); wr(5'h04, 32'h0); wr(5'h08, 32'h5);
    repeat (20) step();
    rd(5'h08, d); check("R8 unmapped read", 64'(d), 64'd0);
    rd(5'h1C, d); check("R8 unmapped read", 64'(d), 64'd0);
    rd(5'h10, d); check("R8 num untouched", 64'(d), 64'hFFFF_F003);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule